// File: doc/BRIEF.md
# Time-shared reloadable perceptron engine

This block holds one perceptron layer whose weights and biases sit in registers that are rewritten at run time. Three feature detectors share that layer in turn: a right-angle corner detector, an acute corner detector and a curved segment detector. A controller serves each binary region image in one pass. For each detector in turn it fills the weight registers from an external weight memory, runs the layer over the region bit buffer, and latches whether that detector saw its feature. The next set is handled the same way.

When all three detectors have run, a small combinational decision stage turns the three flags into one of three sign indicators: round, square or triangular. The indicators are registered and held until the next image completes. The host pulses `start_i` and waits for `done_o`. Each neuron reads one-bit pixels. It adds its signed weight for every pixel that is 1, then adds its bias, and fires when the total is strictly positive.

Top module: `pe_engine`

## Requirements
- R1: While reset is applied, and in the cycles after it, `busy_o`, `done_o` and all three indicator outputs are 0.
- R2: Detector set s (0 = right-angle, 1 = acute, 2 = curved) holds N_NEURON*(N_PIX+1) memory words. Neuron n's weight for pixel p is at address s*N_NEURON*(N_PIX+1) + n*(N_PIX+1) + p, and its bias is at p = N_PIX. The sets are loaded and evaluated in the order 0, 1, 2 for every image.
- R3: A neuron's total is its bias plus the two's-complement weights of all pixels equal to 1. It fires only when the total is strictly greater than zero, so a total of exactly zero does not fire.
- R4: A detector flag is set when at least one neuron of its layer fires.
- R5: The right-angle flag maps to `led_square_o`, the acute flag to `led_tri_o` and the curved flag to `led_round_o`.
- R6: When more than one flag is set, the indicator chosen is triangular first, then square, then round. With no flag set, all indicators are off. At most one indicator is ever lit.
- R7: `busy_o` rises in the cycle after an accepted start and stays high until `done_o`. A start that arrives while busy is ignored and does not cause a second run.
- R8: `done_o` is a one-cycle pulse. The indicators take their new value in the same cycle and hold it until the next `done_o`, even if the pixel buffer changes.
- R9: The weights are re-read from memory for every image, so a change to the weight memory takes effect on the next image.
- R10: A full image completes within 3*(N_NEURON*(N_PIX+1) + N_PIX + 8) + 4 cycles of the start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Pulse that begins processing of the buffered image |
| busy_o | output | 1 | High while an image is being processed |
| done_o | output | 1 | One-cycle pulse when the indicators are updated |
| pix_addr_o | output | $clog2(N_PIX) | Region bit buffer read address |
| pix_bit_i | input | 1 | Pixel bit, valid one cycle after its address |
| wmem_addr_o | output | $clog2(3*N_NEURON*(N_PIX+1)) | Weight memory read address |
| wmem_data_i | input | W_W | Signed weight word, valid one cycle after its address |
| led_round_o | output | 1 | Round sign indicator |
| led_square_o | output | 1 | Square sign indicator |
| led_tri_o | output | 1 | Triangular sign indicator |

## Verification
A fixed weight memory is used, and a table of region images is chosen so that each image lights exactly one detector, several detectors, or none. The single-detector images confirm the mapping from detector to indicator. The multi-detector images separate the priority order from that mapping. Images whose totals land exactly on zero, or depend on a negative weight cancelling a positive one, separate the strict comparison and the signed accumulation from a sloppy threshold. A later edit of one bias in memory shows that the weights really are reloaded per image, and a held indicator with the pixel buffer changed shows the indicator register is decoupled from the datapath.

// File: rtl/pe_pkg.sv
package pe_pkg;

  localparam int NUM_SETS = 3;

  // detector identities, in evaluation order
  typedef enum logic [1:0] {
    DET_RIGHT = 2'd0,
    DET_ACUTE = 2'd1,
    DET_CURVE = 2'd2
  } det_id_t;

  typedef enum logic [3:0] {
    ST_IDLE   = 4'd0,
    ST_LOAD0  = 4'd1,
    ST_EVAL0  = 4'd2,
    ST_LATCH0 = 4'd3,
    ST_LOAD1  = 4'd4,
    ST_EVAL1  = 4'd5,
    ST_LATCH1 = 4'd6,
    ST_LOAD2  = 4'd7,
    ST_EVAL2  = 4'd8,
    ST_LATCH2 = 4'd9,
    ST_DONE   = 4'd10
  } ctrl_st_t;

endpackage

// File: rtl/pe_rst_sync.sv
module pe_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;
endmodule

// File: rtl/pe_wbank.sv
// Reloadable weight registers plus the loader that streams one set in.
module pe_wbank #(
  parameter int N_PIX    = 16,
  parameter int N_NEURON = 2,
  parameter int W_W      = 8,
  parameter int N_SETS   = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  go_i,
  input  logic [1:0]            set_i,
  output logic [$clog2(N_SETS*N_NEURON*(N_PIX+1))-1:0] mem_addr_o,
  input  logic signed [W_W-1:0] mem_data_i,
  output logic                  done_o,
  output logic signed [W_W-1:0] wgt_o [N_NEURON][N_PIX+1]
);
  localparam int WPS = N_NEURON * (N_PIX + 1);
  localparam int WA  = $clog2(N_SETS * WPS);
  localparam int CW  = $clog2(WPS);
  localparam int NW  = (N_NEURON > 1) ? $clog2(N_NEURON) : 1;
  localparam int PW  = $clog2(N_PIX + 1);

  logic          active_q;
  logic [CW-1:0] cnt_q;
  logic [WA-1:0] base_q;
  logic [NW-1:0] n_q;
  logic [PW-1:0] p_q;
  logic          vld_q;
  logic          last_q;
  logic [NW-1:0] wn_q;
  logic [PW-1:0] wp_q;
  logic          done_q;
  logic          last_issue;

  assign last_issue = active_q && (cnt_q == CW'(WPS - 1));

  // issue side: one address per cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      base_q   <= '0;
      n_q      <= '0;
      p_q      <= '0;
    end else if (go_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      base_q   <= WA'(set_i) * WA'(WPS);
      n_q      <= '0;
      p_q      <= '0;
    end else if (active_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (p_q == PW'(N_PIX)) begin
        p_q <= '0;
        n_q <= n_q + 1'b1;
      end else begin
        p_q <= p_q + 1'b1;
      end
      if (last_issue) active_q <= 1'b0;
    end
  end

  // return side: data arrives one cycle after its address
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      last_q <= 1'b0;
      wn_q   <= '0;
      wp_q   <= '0;
      done_q <= 1'b0;
    end else begin
      vld_q  <= active_q;
      last_q <= last_issue;
      wn_q   <= n_q;
      wp_q   <= p_q;
      done_q <= vld_q && last_q;
    end
  end

  assign mem_addr_o = base_q + WA'(cnt_q);
  assign done_o     = done_q;

  for (genvar n = 0; n < N_NEURON; n++) begin : g_neu
    for (genvar p = 0; p <= N_PIX; p++) begin : g_px
      logic signed [W_W-1:0] w_q;
      logic                  wr_en;
      assign wr_en = vld_q && (wn_q == NW'(n)) && (wp_q == PW'(p));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     w_q <= '0;
        else if (wr_en) w_q <= mem_data_i;
      end
      assign wgt_o[n][p] = w_q;
    end
  end
endmodule

// File: rtl/pe_layer.sv
// Self-sequencing single perceptron layer over one-bit pixels.
module pe_layer #(
  parameter int N_PIX    = 16,
  parameter int N_NEURON = 2,
  parameter int W_W      = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      go_i,
  input  logic signed [W_W-1:0]     wgt_i [N_NEURON][N_PIX+1],
  output logic [$clog2(N_PIX)-1:0]  pix_addr_o,
  input  logic                      pix_bit_i,
  output logic                      done_o,
  output logic [N_NEURON-1:0]       fire_o
);
  localparam int PA  = $clog2(N_PIX);
  localparam int ACW = W_W + $clog2(N_PIX + 1) + 1;

  logic          active_q;
  logic [PA-1:0] cnt_q;
  logic          vld_q;
  logic [PA-1:0] pidx_q;
  logic          done_q;
  logic          fin;

  assign fin = vld_q && (pidx_q == PA'(N_PIX - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (go_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (active_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == PA'(N_PIX - 1)) active_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      pidx_q <= '0;
      done_q <= 1'b0;
    end else begin
      vld_q  <= active_q;
      pidx_q <= cnt_q;
      done_q <= fin;
    end
  end

  assign pix_addr_o = cnt_q;
  assign done_o     = done_q;

  for (genvar n = 0; n < N_NEURON; n++) begin : g_neu
    logic signed [ACW-1:0] acc_q;
    logic signed [ACW-1:0] w_ext;
    logic signed [ACW-1:0] b_ext;
    logic signed [ACW-1:0] add_w;
    logic signed [ACW-1:0] tot_w;
    logic                  fire_q;

    assign w_ext = {{(ACW-W_W){wgt_i[n][pidx_q][W_W-1]}}, wgt_i[n][pidx_q]};
    assign b_ext = {{(ACW-W_W){wgt_i[n][N_PIX][W_W-1]}}, wgt_i[n][N_PIX]};
    assign add_w = pix_bit_i ? (acc_q + w_ext) : acc_q;
    assign tot_w = add_w + b_ext;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_q  <= '0;
        fire_q <= 1'b0;
      end else begin
        if (go_i)       acc_q <= '0;
        else if (vld_q) acc_q <= add_w;
        if (fin)        fire_q <= !tot_w[ACW-1] && (tot_w != '0);
      end
    end

    assign fire_o[n] = fire_q;
  end
endmodule

// File: rtl/pe_decide.sv
// Flag-to-indicator mapping with fixed priority.
module pe_decide (
  input  logic [2:0] flag_i,
  output logic       round_o,
  output logic       square_o,
  output logic       tri_o
);
  always_comb begin
    tri_o    = flag_i[pe_pkg::DET_ACUTE];
    square_o = flag_i[pe_pkg::DET_RIGHT] && !flag_i[pe_pkg::DET_ACUTE];
    round_o  = flag_i[pe_pkg::DET_CURVE] && !flag_i[pe_pkg::DET_ACUTE]
               && !flag_i[pe_pkg::DET_RIGHT];
  end
endmodule

// File: rtl/pe_engine.sv
module pe_engine
  import pe_pkg::*;
#(
  parameter int N_PIX    = 16,
  parameter int N_NEURON = 2,
  parameter int W_W      = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic [$clog2(N_PIX)-1:0] pix_addr_o,
  input  logic                  pix_bit_i,
  output logic [$clog2(NUM_SETS*N_NEURON*(N_PIX+1))-1:0] wmem_addr_o,
  input  logic signed [W_W-1:0] wmem_data_i,
  output logic                  led_round_o,
  output logic                  led_square_o,
  output logic                  led_tri_o
);
  logic                  rst_q_n;
  ctrl_st_t              state_q, state_d;
  logic                  load_go, eval_go;
  det_id_t               go_set;
  logic                  ld_done, ev_done;
  logic [N_NEURON-1:0]   fire;
  logic signed [W_W-1:0] wgt [N_NEURON][N_PIX+1];
  logic [NUM_SETS-1:0]   flag_q, flag_d;
  logic                  flag_en;
  logic                  dec_round, dec_square, dec_tri;
  logic [2:0]            led_q, led_d;
  logic                  led_en;
  logic                  done_q;

  pe_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  pe_wbank #(
    .N_PIX(N_PIX), .N_NEURON(N_NEURON), .W_W(W_W), .N_SETS(NUM_SETS)
  ) u_wbank (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .go_i       (load_go),
    .set_i      (go_set),
    .mem_addr_o (wmem_addr_o),
    .mem_data_i (wmem_data_i),
    .done_o     (ld_done),
    .wgt_o      (wgt)
  );

  pe_layer #(
    .N_PIX(N_PIX), .N_NEURON(N_NEURON), .W_W(W_W)
  ) u_layer (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .go_i       (eval_go),
    .wgt_i      (wgt),
    .pix_addr_o (pix_addr_o),
    .pix_bit_i  (pix_bit_i),
    .done_o     (ev_done),
    .fire_o     (fire)
  );

  pe_decide u_dec (
    .flag_i   (flag_q),
    .round_o  (dec_round),
    .square_o (dec_square),
    .tri_o    (dec_tri)
  );

  // controller next state
  always_comb begin
    state_d = state_q;
    load_go = 1'b0;
    eval_go = 1'b0;
    go_set  = DET_RIGHT;
    flag_en = 1'b0;
    flag_d  = flag_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_LOAD0; load_go = 1'b1; go_set = DET_RIGHT;
      end
      ST_LOAD0:  if (ld_done) begin state_d = ST_EVAL0; eval_go = 1'b1; end
      ST_EVAL0:  if (ev_done) state_d = ST_LATCH0;
      ST_LATCH0: begin
        flag_en = 1'b1; flag_d[DET_RIGHT] = |fire;
        state_d = ST_LOAD1; load_go = 1'b1; go_set = DET_ACUTE;
      end
      ST_LOAD1:  if (ld_done) begin state_d = ST_EVAL1; eval_go = 1'b1; end
      ST_EVAL1:  if (ev_done) state_d = ST_LATCH1;
      ST_LATCH1: begin
        flag_en = 1'b1; flag_d[DET_ACUTE] = |fire;
        state_d = ST_LOAD2; load_go = 1'b1; go_set = DET_CURVE;
      end
      ST_LOAD2:  if (ld_done) begin state_d = ST_EVAL2; eval_go = 1'b1; end
      ST_EVAL2:  if (ev_done) state_d = ST_LATCH2;
      ST_LATCH2: begin
        flag_en = 1'b1; flag_d[DET_CURVE] = |fire;
        state_d = ST_DONE;
      end
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  assign led_en = (state_q == ST_DONE);
  assign led_d  = {dec_tri, dec_square, dec_round};

  // controller registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      state_q <= ST_IDLE;
      flag_q  <= '0;
      led_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (flag_en) flag_q <= flag_d;
      if (led_en)  led_q  <= led_d;
      done_q <= led_en;
    end
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = done_q;
  assign led_round_o  = led_q[0];
  assign led_square_o = led_q[1];
  assign led_tri_o    = led_q[2];
endmodule

// File: rtl/pe_engine_chk.sv
module pe_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic led_round_o,
  input logic led_square_o,
  input logic led_tri_o
);
  AST_LED_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({led_tri_o, led_square_o, led_round_o})); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8

  AST_LED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable({led_tri_o, led_square_o, led_round_o})); // R8

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o); // R7

  AST_BUSY_TILL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o); // R7

  AST_NO_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !done_o) |=> !done_o); // R7
endmodule

bind pe_engine pe_engine_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_q_n),
  .start_i      (start_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .led_round_o  (led_round_o),
  .led_square_o (led_square_o),
  .led_tri_o    (led_tri_o)
);

// File: tb/sim_pe_engine.sv
`timescale 1ns/1ps
module sim_pe_engine;
  localparam int NP    = 16;
  localparam int NN    = 2;
  localparam int WPS   = NN * (NP + 1);
  localparam int BOUND = 3 * (WPS + NP + 8) + 4;

  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic busy, done;
  logic [3:0] paddr;
  logic pbit;
  logic [6:0] waddr;
  logic signed [7:0] wdata;
  logic l_round, l_square, l_tri;

  logic signed [7:0] wmem [0:127];
  logic              pix  [0:NP-1];
  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  always_ff @(posedge clk) begin
    wdata <= wmem[waddr];
    pbit  <= pix[paddr];
  end

  pe_engine #(.N_PIX(NP), .N_NEURON(NN), .W_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy), .done_o(done),
    .pix_addr_o(paddr), .pix_bit_i(pbit), .wmem_addr_o(waddr),
    .wmem_data_i(wdata), .led_round_o(l_round), .led_square_o(l_square),
    .led_tri_o(l_tri)
  );

  // {image, expected {tri, square, round}}
  localparam logic [18:0] VEC [11] = '{
    {16'h0000, 3'b000},  // R4 nothing fires
    {16'h000F, 3'b010},  // R5 right-angle only -> square
    {16'h0030, 3'b100},  // R5 acute only -> triangular
    {16'h3F00, 3'b001},  // R5 curved only -> round
    {16'h1F00, 3'b000},  // R3 total exactly zero does not fire
    {16'h0001, 3'b001},  // R4 second neuron alone sets the flag
    {16'h0003, 3'b000},  // R3 negative weight cancels
    {16'h003F, 3'b100},  // R6 triangular beats square
    {16'hFF0F, 3'b010},  // R6 square beats round
    {16'hFF3F, 3'b100},  // R6 all flags
    {16'hFF00, 3'b001}   // R2 set 2 evaluated
  };

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int wa(int s, int n, int p);
    return s * WPS + n * (NP + 1) + p;
  endfunction

  task automatic set_img(input logic [15:0] img);
    for (int i = 0; i < NP; i++) pix[i] = img[i];
  endtask

  task automatic run_img(input logic [15:0] img, output int cyc, output logic [2:0] leds);
    set_img(img);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    cyc = 1;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    leds = {l_tri, l_square, l_round};
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cyc;
    int dn;
    logic [2:0] leds;
    for (int i = 0; i < 128; i++) wmem[i] = '0;
    // set 0: right-angle
    for (int p = 0; p < 4; p++) wmem[wa(0,0,p)] = 8'sd1;
    wmem[wa(0,0,NP)] = -8'sd3;
    // set 1: acute
    wmem[wa(1,0,4)] = 8'sd2;
    wmem[wa(1,0,5)] = 8'sd2;
    wmem[wa(1,0,NP)] = -8'sd3;
    wmem[wa(1,1,NP)] = -8'sd1;
    // set 2: curved
    for (int p = 8; p < 16; p++) wmem[wa(2,0,p)] = 8'sd1;
    wmem[wa(2,0,NP)] = -8'sd5;
    wmem[wa(2,1,0)]  = 8'sd3;
    wmem[wa(2,1,1)]  = -8'sd5;
    wmem[wa(2,1,NP)] = -8'sd2;
    set_img(16'h0000);

    rst_n = 1'b0;
    start = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 leds in reset", {l_tri, l_square, l_round}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 busy after reset", busy, 0);
    chk("R1 done after reset", done, 0);
    chk("R1 leds after reset", {l_tri, l_square, l_round}, 0);

    // main table
    for (int v = 0; v < 11; v++) begin
      run_img(VEC[v][18:3], cyc, leds);
      chk($sformatf("R5/R6 vector %0d leds", v), leds, VEC[v][2:0]);
      chk($sformatf("R10 vector %0d latency ok", v), (cyc <= BOUND) ? 1 : 0, 1);
      @(negedge clk);
      chk($sformatf("R8 vector %0d done one cycle", v), done, 0);
    end

    // R8: indicators hold while the buffer changes
    run_img(16'h0030, cyc, leds);
    set_img(16'h3F00);
    repeat (30) @(negedge clk);
    chk("R8 leds held", {l_tri, l_square, l_round}, 3'b100);

    // R7: start while busy ignored
    set_img(16'h000F);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk("R7 busy after start", busy, 1);
    repeat (10) @(negedge clk);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    dn = 0;
    for (int i = 0; i < 3 * BOUND; i++) begin
      @(negedge clk);
      if (done) dn++;
    end
    chk("R7 single done for two starts", dn, 1);
    chk("R7 idle after run", busy, 0);
    chk("R7 leds of first run", {l_tri, l_square, l_round}, 3'b010);

    // R9: weight memory edit takes effect on the next image
    run_img(16'h0000, cyc, leds);
    chk("R9 before edit", leds, 3'b000);
    wmem[wa(0,1,NP)] = 8'sd1;
    run_img(16'h0000, cyc, leds);
    chk("R9 after bias edit", leds, 3'b010);
    wmem[wa(0,1,NP)] = 8'sd0;
    run_img(16'h0000, cyc, leds);
    chk("R9 after restore", leds, 3'b000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule